// File: doc/BRIEF.md
# Reclocker Rate Control

This block is the control and status logic that sits beside the clock-recovery loop of a multi-rate serial reclocker. A small configuration register holds a two-bit rate selection, an auto-bypass enable and an indicator mode bit. From that configuration and from three inputs supplied by an external rate detector and lock detector, the block drives four outputs:

- the rate code handed to the clock-recovery loop,
- a bypass control,
- a qualified lock flag,
- a standard-definition / high-definition indicator meant for the edge-speed control of a downstream cable driver.

The rate can be fixed by hand, or the block can follow the detector. In manual mode a signal at exactly twice the programmed rate is also accepted as locked. In automatic mode, a rate the detector cannot resolve can make the block fall back to bypass, so that data at other rates passes straight through. All outputs are registered. Every port is a plain level signal, because no data stream passes through the block and so there is no handshake or back-pressure.

Top module: `reclk_rate_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) does three things. It loads the configuration with rate field 0 (automatic), auto-bypass enable 1 and indicator mode 0, so `cfg_rdata` reads 4'b0100. It clears all four outputs to 0.
- R2: When `cfg_wr_en` is high at a clock edge, `cfg_wdata` is stored. `cfg_rdata` returns the stored value, with this field layout: bits [1:0] rate field, bit 2 auto-bypass enable, bit 3 indicator mode.
- R3: Rate codes are 0 for unknown, 1 for SD (270 Mbps), 2 for HD (1485 Mbps) and 3 for 3G (2970 Mbps). A non-zero rate field is a manual mode. In a manual mode, `cdr_rate_o` equals the rate field and `bypass_o` is 0.
- R4: In a manual mode, `rate_locked_o` is 1 only when all of these hold: `lock_i` is 1, `det_valid_i` is 1, and the detected rate equals either the programmed rate or exactly twice it (HD programmed accepts a 3G detection).
- R5: In automatic mode (rate field 0) with a resolved detection (`det_valid_i` 1 and `det_rate_i` non-zero), three things hold. `cdr_rate_o` equals `det_rate_i`. `bypass_o` is 0. `rate_locked_o` equals `lock_i`.
- R6: In automatic mode with an unresolved detection and auto-bypass enable 1, `bypass_o` is 1, `cdr_rate_o` is 0 and `rate_locked_o` is 0.
- R7: When auto-bypass enable is 0, `bypass_o` is never 1. An unresolved detection in automatic mode gives `cdr_rate_o` 0 and `rate_locked_o` 0.
- R8: With indicator mode 0, `sd_ind_o` is 1 only when `rate_locked_o` is 1 and the detected rate is SD. At all other times it is 0, the fast-edge state.
- R9: With indicator mode 1, `sd_ind_o` is 1 when `lock_i` is 1, `bypass_o` is 0 and `cdr_rate_o` is SD, and 0 otherwise. HD and 3G therefore both report low.
- R10: Each output reflects the inputs sampled at the previous clock edge and the configuration stored before that edge. A change on a detector input shows after one edge. A register write shows on the outputs one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write data |
| cfg_rdata | output | 4 | Stored configuration |
| det_rate_i | input | 2 | Rate code from the rate detector |
| det_valid_i | input | 1 | Rate detector result is valid |
| lock_i | input | 1 | Frequency lock flag from the lock detector |
| cdr_rate_o | output | 2 | Rate code driven to the clock-recovery loop |
| bypass_o | output | 1 | Bypass control |
| rate_locked_o | output | 1 | Lock qualified against the selected rate |
| sd_ind_o | output | 1 | SD/HD indicator, high for SD |

## Verification
A detector or lock input that changes between edges is due on the outputs after the next rising edge. A configuration write is due one edge after the edge that stores it. The sweep therefore writes each configuration, drives each detector pattern, lets two rising edges pass and compares at the following falling edge. Two directed cases sample both before and after the due edge, which confirms that the one-cycle latency of inputs and the extra cycle after a write are exact.

// File: rtl/reclk_rate_pkg.sv
package reclk_rate_pkg;

  localparam int RATE_W = 2;
  localparam int CFG_W  = RATE_W + 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_NONE = 2'd0,
    RATE_SD   = 2'd1,
    RATE_HD   = 2'd2,
    RATE_3G   = 2'd3
  } rate_e;

  typedef struct packed {
    logic  ind_mode;
    logic  ab_en;
    rate_e sel;
  } cfg_t;

  localparam cfg_t CFG_RST = '{ind_mode: 1'b0, ab_en: 1'b1, sel: RATE_NONE};

  // Nominal line rate in Mbps for each code, used for harmonic matching.
  function automatic int unsigned rate_mbps(rate_e r);
    case (r)
      RATE_SD: rate_mbps = 270;
      RATE_HD: rate_mbps = 1485;
      RATE_3G: rate_mbps = 2970;
      default: rate_mbps = 0;
    endcase
  endfunction

endpackage

// File: rtl/reclk_cfg_reg.sv
module reclk_cfg_reg
  import reclk_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);

  always_ff @(posedge clk) begin
    if (rst)        cfg <= CFG_RST;
    else if (wr_en) cfg <= cfg_t'(wdata);
  end

endmodule

// File: rtl/reclk_rate_sel.sv
module reclk_rate_sel
  import reclk_rate_pkg::*;
#(
  parameter int HARMONIC = 2
) (
  input  cfg_t  cfg,
  input  rate_e det_rate,
  input  logic  det_valid,
  input  logic  lock,
  output rate_e nxt_rate,
  output logic  nxt_bypass,
  output logic  nxt_locked
);

  logic resolved;
  logic manual;
  logic match;

  assign resolved = det_valid && (det_rate != RATE_NONE);
  assign manual   = (cfg.sel != RATE_NONE);
  assign match    = (det_rate == cfg.sel) ||
                    (rate_mbps(det_rate) == HARMONIC * rate_mbps(cfg.sel));

  always_comb begin
    nxt_rate   = RATE_NONE;
    nxt_bypass = 1'b0;
    nxt_locked = 1'b0;
    if (manual) begin
      nxt_rate   = cfg.sel;
      nxt_locked = lock && resolved && match;
    end else if (resolved) begin
      nxt_rate   = det_rate;
      nxt_locked = lock;
    end else begin
      nxt_bypass = cfg.ab_en;
    end
  end

endmodule

// File: rtl/reclk_sd_ind.sv
module reclk_sd_ind
  import reclk_rate_pkg::*;
(
  input  logic  mode,
  input  logic  lock,
  input  logic  qual_locked,
  input  logic  bypass,
  input  rate_e det_rate,
  input  rate_e act_rate,
  output logic  ind
);

  always_comb begin
    if (!mode) ind = qual_locked && (det_rate == RATE_SD);
    else       ind = lock && !bypass && (act_rate == RATE_SD);
  end

endmodule

// File: rtl/reclk_rate_ctrl.sv
module reclk_rate_ctrl
  import reclk_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [RATE_W-1:0] det_rate_i,
  input  logic              det_valid_i,
  input  logic              lock_i,
  output logic [RATE_W-1:0] cdr_rate_o,
  output logic              bypass_o,
  output logic              rate_locked_o,
  output logic              sd_ind_o
);

  cfg_t  cfg;
  rate_e det_rate;
  rate_e nxt_rate;
  logic  nxt_bypass;
  logic  nxt_locked;
  logic  nxt_ind;

  assign det_rate  = rate_e'(det_rate_i);
  assign cfg_rdata = CFG_W'(cfg);

  reclk_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  reclk_rate_sel #(.HARMONIC(2)) u_sel (
    .cfg        (cfg),
    .det_rate   (det_rate),
    .det_valid  (det_valid_i),
    .lock       (lock_i),
    .nxt_rate   (nxt_rate),
    .nxt_bypass (nxt_bypass),
    .nxt_locked (nxt_locked)
  );

  reclk_sd_ind u_ind (
    .mode        (cfg.ind_mode),
    .lock        (lock_i),
    .qual_locked (nxt_locked),
    .bypass      (nxt_bypass),
    .det_rate    (det_rate),
    .act_rate    (nxt_rate),
    .ind         (nxt_ind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cdr_rate_o    <= '0;
      bypass_o      <= 1'b0;
      rate_locked_o <= 1'b0;
      sd_ind_o      <= 1'b0;
    end else begin
      cdr_rate_o    <= nxt_rate;
      bypass_o      <= nxt_bypass;
      rate_locked_o <= nxt_locked;
      sd_ind_o      <= nxt_ind;
    end
  end

endmodule

// File: rtl/reclk_rate_ctrl_chk.sv
module reclk_rate_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cfg_rdata,
  input logic [1:0] det_rate_i,
  input logic       det_valid_i,
  input logic       lock_i,
  input logic [1:0] cdr_rate_o,
  input logic       bypass_o,
  input logic       rate_locked_o,
  input logic       sd_ind_o
);

  p_manual_no_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[1:0] != 2'd0) |=> !bypass_o);

  p_manual_rate_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[1:0] != 2'd0) |=> (cdr_rate_o == $past(cfg_rdata[1:0])));

  p_unresolved_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    ((cfg_rdata[2:0] == 3'b100) && !(det_valid_i && det_rate_i != 2'd0)) |=> bypass_o);

  p_bypass_unknown_rate_r6: assert property (@(posedge clk) disable iff (rst)
    bypass_o |-> (cdr_rate_o == 2'd0) && !rate_locked_o);

  p_no_bypass_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[2] |=> !bypass_o);

  p_ind_needs_lock_r8: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> !sd_ind_o);

  p_hd_3g_low_r9: assert property (@(posedge clk) disable iff (rst)
    (cdr_rate_o[1] && !bypass_o) |-> !sd_ind_o);

endmodule

bind reclk_rate_ctrl reclk_rate_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_rdata     (cfg_rdata),
  .det_rate_i    (det_rate_i),
  .det_valid_i   (det_valid_i),
  .lock_i        (lock_i),
  .cdr_rate_o    (cdr_rate_o),
  .bypass_o      (bypass_o),
  .rate_locked_o (rate_locked_o),
  .sd_ind_o      (sd_ind_o)
);

// File: tb/reclk_rate_ctrl_tb.sv
`timescale 1ns/1ps
module reclk_rate_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_rdata;
  logic [1:0] det_rate_i = '0;
  logic       det_valid_i = 1'b0;
  logic       lock_i = 1'b0;
  logic [1:0] cdr_rate_o;
  logic       bypass_o;
  logic       rate_locked_o;
  logic       sd_ind_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reclk_rate_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .det_rate_i(det_rate_i), .det_valid_i(det_valid_i),
    .lock_i(lock_i), .cdr_rate_o(cdr_rate_o), .bypass_o(bypass_o),
    .rate_locked_o(rate_locked_o), .sd_ind_o(sd_ind_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mbps(input int c);
    return (c == 1) ? 270 : (c == 2) ? 1485 : (c == 3) ? 2970 : 0;
  endfunction

  task automatic write_cfg(input int v);
    @(negedge clk);
    cfg_wdata = 4'(v);
    cfg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "cfg_rdata", int'(cfg_rdata), 4);
    check("R1", "outputs", int'({cdr_rate_o, bypass_o, rate_locked_o, sd_ind_o}), 0);
    rst = 1'b0;

    for (int cfg = 0; cfg < 16; cfg++) begin
      write_cfg(cfg);
      check("R2", "cfg_rdata", int'(cfg_rdata), cfg);
      for (int v = 0; v < 2; v++)
        for (int d = 0; d < 4; d++)
          for (int l = 0; l < 2; l++) begin
            int sel, ab, md, er, eb, el, ei;
            bit res;
            sel = cfg & 3; ab = (cfg >> 2) & 1; md = (cfg >> 3) & 1;
            res = (v == 1) && (d != 0);
            @(negedge clk);
            det_valid_i = 1'(v); det_rate_i = 2'(d); lock_i = 1'(l);
            if (sel != 0) begin
              er = sel; eb = 0;
              el = (l == 1 && res && (d == sel || mbps(d) == 2 * mbps(sel))) ? 1 : 0;
            end else if (res) begin
              er = d; eb = 0; el = l;
            end else begin
              er = 0; eb = ab; el = 0;
            end
            if (md == 0) ei = (el == 1 && d == 1) ? 1 : 0;
            else         ei = (l == 1 && eb == 0 && er == 1) ? 1 : 0;
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check(sel != 0 ? "R3" : "R5", "cdr_rate_o", int'(cdr_rate_o), er);
            check(ab != 0 ? "R6" : "R7", "bypass_o", int'(bypass_o), eb);
            check(sel != 0 ? "R4" : "R5", "rate_locked_o", int'(rate_locked_o), el);
            check(md != 0 ? "R9" : "R8", "sd_ind_o", int'(sd_ind_o), ei);
          end
    end

    // R10: detector change latency, manual HD locked on a 3G harmonic
    write_cfg(4'b0010);
    @(negedge clk);
    det_valid_i = 1'b1; det_rate_i = 2'd3; lock_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10", "locked settled", int'(rate_locked_o), 1);
    lock_i = 1'b0;
    #2;
    check("R10", "locked before edge", int'(rate_locked_o), 1);
    @(posedge clk);
    @(negedge clk);
    check("R10", "locked after edge", int'(rate_locked_o), 0);

    // R10: write latency, HD -> SD
    cfg_wdata = 4'b0001;
    cfg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check("R10", "rate one edge after write", int'(cdr_rate_o), 2);
    @(posedge clk);
    @(negedge clk);
    check("R10", "rate two edges after write", int'(cdr_rate_o), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule